// File: doc/BRIEF.md
# Trap and Interrupt Cause Arbiter

This block chooses the single trap that a machine-mode RISC-V core should take in a given cycle. Each cycle it receives the synchronous exception flags from the pipeline, a description of the memory access in flight (used to detect misalignment), the single-step state, and the raw interrupt request lines. The raw request lines are first captured into a registered pending vector. That vector is then masked by the per-source enable word and by the global interrupt enable. A fixed priority scheme picks one winner, either an exception or an interrupt.

The winner leaves the block as a one-cycle `take_o` pulse together with the 32-bit cause value and the handler address. The handler address is derived from the trap-vector word, which is either a single direct entry or a vectored table for interrupts. The block has no handshake at its edge. Every qualifying cycle produces a pulse, and the surrounding core is expected to clear the global enable or flush the offending instruction. Between traps, cause and target keep the last values they were given.

Top module: `trap_cause_arbiter`

## Requirements
- R1: `pending_o` is registered one cycle after the request lines. Bit 11 follows `irq_i[0]` (external), bit 7 follows `timer_i`, and bit 16+k follows `irq_i[k+1]` for local interrupts k = 0..6.
- R2: Every other bit of `pending_o` reads zero, including bit 3 (software interrupt) and bits 31:23.
- R3: An exception flag raises `take_o` one cycle later with cause code 0x0 for fetch misalignment, 0x2 for illegal instruction, 0x3 for breakpoint, 0xB for environment call, 0x4 for load misalignment and 0x6 for store misalignment. Bit 31 of the cause is clear for all of them.
- R4: When several exceptions occur together, the priority is fetch misalignment, then illegal, then breakpoint, then environment call, then load misalignment, then store misalignment.
- R5: When `step_mode_i` and `retire_i` are both high, a breakpoint (cause 0x3) is taken. `step_mode_i` alone takes nothing.
- R6: When `mem_valid_i` is high, an access is misaligned in two cases: a word access (`mem_size_i`=2) with `mem_addr_lo_i` nonzero, or a halfword access (`mem_size_i`=1) with `mem_addr_lo_i[0]` set. Byte accesses (0) and the reserved code 3 are never misaligned. `mem_we_i`=0 selects cause 0x4 and `mem_we_i`=1 selects cause 0x6.
- R7: Any exception in a cycle wins over any interrupt that is pending in the same cycle.
- R8: Among enabled pending interrupts, external wins over timer, timer wins over local interrupts, and a lower local index wins over a higher one.
- R9: An interrupt is taken only when `gie_i` is high and `pending_o & ie_mask_i` is nonzero. Its cause is 0x80000000 plus the pending-bit index: 0x8000000B, 0x80000007, or 0x80000010+k.
- R10: Exceptions, and interrupts when `tvec_i[1:0]` is not 1, target `tvec_i` with bits 1:0 cleared.
- R11: When `tvec_i[1:0]` = 1, an interrupt targets the cleared base plus 4 × (cause bits 4:0).
- R12: `take_o` is high for exactly the cycles that follow a qualifying cycle. While it is low, `cause_o` and `target_o` hold their values.
- R13: During reset, `take_o`, `cause_o`, `target_o` and `pending_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_fetch_i | input | 1 | Fetch target misaligned |
| exc_illegal_i | input | 1 | Illegal instruction |
| exc_ebreak_i | input | 1 | Breakpoint instruction |
| exc_ecall_i | input | 1 | Environment call instruction |
| step_mode_i | input | 1 | Single-step mode bit |
| retire_i | input | 1 | An instruction retires this cycle |
| mem_valid_i | input | 1 | Data access in flight |
| mem_we_i | input | 1 | Access is a store |
| mem_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| mem_addr_lo_i | input | 2 | Access address bits 1:0 |
| irq_i | input | N_LOCAL+1 (8) | Line 0 external, lines 7:1 local 0..6 |
| timer_i | input | 1 | Timer interrupt request |
| gie_i | input | 1 | Global interrupt enable |
| ie_mask_i | input | 32 | Per-source enable, same layout as pending |
| tvec_i | input | 32 | Trap-vector base and mode (bits 1:0) |
| pending_o | output | 32 | Registered pending vector |
| take_o | output | 1 | One-cycle trap pulse |
| cause_o | output | 32 | Cause of the last trap |
| target_o | output | 32 | Handler address of the last trap |

## Verification
The assertions check, on every cycle, several properties that can be stated at the ports. The external pending bit follows its request line with one cycle of delay, and unwired pending bits stay at zero. An illegal instruction, an environment call or a single-step retirement always produces the expected trap class. Nothing is taken when the global enable is low and no exception source is active. Cause and target hold between pulses. The full priority chains, the misalignment truth table across sizes and offsets, the vectored target arithmetic and the mask interplay among several pending interrupts only show up in the bench's scenarios, which compare every output cycle against an independently computed expectation.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  localparam logic [4:0] CODE_FETCH   = 5'd0;
  localparam logic [4:0] CODE_ILLEGAL = 5'd2;
  localparam logic [4:0] CODE_BREAK   = 5'd3;
  localparam logic [4:0] CODE_LOAD    = 5'd4;
  localparam logic [4:0] CODE_STORE   = 5'd6;
  localparam logic [4:0] CODE_ECALL   = 5'd11;

  typedef struct packed {
    logic       hit;
    logic [4:0] code;
  } trap_pick_t;
endpackage

// File: rtl/trap_misalign_chk.sv
module trap_misalign_chk
  import trap_pkg::*;
(
  input  logic       valid_i,
  input  logic       we_i,
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  output logic       load_mis_o,
  output logic       store_mis_o
);
  acc_size_e size;
  logic      bad;

  always_comb begin
    size = acc_size_e'(size_i);
    unique case (size)
      SZ_WORD: bad = (addr_lo_i != 2'b00);
      SZ_HALF: bad = addr_lo_i[0];
      default: bad = 1'b0;
    endcase
  end

  assign load_mis_o  = valid_i & bad & ~we_i;
  assign store_mis_o = valid_i & bad & we_i;
endmodule

// File: rtl/trap_pending_reg.sv
module trap_pending_reg
  import trap_pkg::*;
#(
  parameter int N_LOCAL    = 7,
  parameter int LOCAL_BASE = 16,
  parameter int EXT_BIT    = 11,
  parameter int TIMER_BIT  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LOCAL:0] irq_i,
  input  logic             timer_i,
  output logic [XLEN-1:0]  pend_o
);
  logic [N_LOCAL-1:0] local_req;
  logic [XLEN-1:0]    pend_d;

  for (genvar k = 0; k < N_LOCAL; k++) begin : g_local
    assign local_req[k] = irq_i[k+1];
  end

  always_comb begin
    pend_d = '0;
    pend_d[EXT_BIT]   = irq_i[0];
    pend_d[TIMER_BIT] = timer_i;
    pend_d[LOCAL_BASE +: N_LOCAL] = local_req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_d;
  end
endmodule

// File: rtl/trap_exc_select.sv
module trap_exc_select
  import trap_pkg::*;
(
  input  logic       fetch_i,
  input  logic       illegal_i,
  input  logic       brk_i,
  input  logic       ecall_i,
  input  logic       load_i,
  input  logic       store_i,
  output trap_pick_t pick_o
);
  always_comb begin
    pick_o = '0;
    if      (fetch_i)   pick_o = '{hit: 1'b1, code: CODE_FETCH};
    else if (illegal_i) pick_o = '{hit: 1'b1, code: CODE_ILLEGAL};
    else if (brk_i)     pick_o = '{hit: 1'b1, code: CODE_BREAK};
    else if (ecall_i)   pick_o = '{hit: 1'b1, code: CODE_ECALL};
    else if (load_i)    pick_o = '{hit: 1'b1, code: CODE_LOAD};
    else if (store_i)   pick_o = '{hit: 1'b1, code: CODE_STORE};
  end
endmodule

// File: rtl/trap_irq_select.sv
module trap_irq_select
  import trap_pkg::*;
#(
  parameter int N_LOCAL    = 7,
  parameter int LOCAL_BASE = 16,
  parameter int EXT_BIT    = 11,
  parameter int TIMER_BIT  = 7
) (
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic            gie_i,
  output trap_pick_t      pick_o
);
  logic [XLEN-1:0] req;

  always_comb begin
    req    = pend_i & mask_i;
    pick_o = '0;
    for (int k = N_LOCAL - 1; k >= 0; k--) begin
      if (req[LOCAL_BASE + k]) pick_o = '{hit: 1'b1, code: 5'(LOCAL_BASE + k)};
    end
    if (req[TIMER_BIT]) pick_o = '{hit: 1'b1, code: 5'(TIMER_BIT)};
    if (req[EXT_BIT])   pick_o = '{hit: 1'b1, code: 5'(EXT_BIT)};
    if (!gie_i)         pick_o = '0;
  end
endmodule

// File: rtl/trap_cause_arbiter.sv
module trap_cause_arbiter
  import trap_pkg::*;
#(
  parameter int N_LOCAL    = 7,
  parameter int LOCAL_BASE = 16,
  parameter int EXT_BIT    = 11,
  parameter int TIMER_BIT  = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exc_fetch_i,
  input  logic             exc_illegal_i,
  input  logic             exc_ebreak_i,
  input  logic             exc_ecall_i,
  input  logic             step_mode_i,
  input  logic             retire_i,
  input  logic             mem_valid_i,
  input  logic             mem_we_i,
  input  logic [1:0]       mem_size_i,
  input  logic [1:0]       mem_addr_lo_i,
  input  logic [N_LOCAL:0] irq_i,
  input  logic             timer_i,
  input  logic             gie_i,
  input  logic [31:0]      ie_mask_i,
  input  logic [31:0]      tvec_i,
  output logic [31:0]      pending_o,
  output logic             take_o,
  output logic [31:0]      cause_o,
  output logic [31:0]      target_o
);
  localparam logic [1:0] MODE_VECTORED = 2'b01;

  logic       load_mis, store_mis, brk;
  trap_pick_t exc_pick, irq_pick;
  logic [XLEN-1:0] pend_q, base, cause_d, target_d;
  logic            take_d;
  logic            take_q;
  logic [XLEN-1:0] cause_q, target_q;

  trap_misalign_chk u_mis (
    .valid_i     (mem_valid_i),
    .we_i        (mem_we_i),
    .size_i      (mem_size_i),
    .addr_lo_i   (mem_addr_lo_i),
    .load_mis_o  (load_mis),
    .store_mis_o (store_mis)
  );

  trap_pending_reg #(
    .N_LOCAL(N_LOCAL), .LOCAL_BASE(LOCAL_BASE), .EXT_BIT(EXT_BIT), .TIMER_BIT(TIMER_BIT)
  ) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .timer_i (timer_i),
    .pend_o  (pend_q)
  );

  assign brk = exc_ebreak_i | (step_mode_i & retire_i);

  trap_exc_select u_exc (
    .fetch_i   (exc_fetch_i),
    .illegal_i (exc_illegal_i),
    .brk_i     (brk),
    .ecall_i   (exc_ecall_i),
    .load_i    (load_mis),
    .store_i   (store_mis),
    .pick_o    (exc_pick)
  );

  trap_irq_select #(
    .N_LOCAL(N_LOCAL), .LOCAL_BASE(LOCAL_BASE), .EXT_BIT(EXT_BIT), .TIMER_BIT(TIMER_BIT)
  ) u_irq (
    .pend_i (pend_q),
    .mask_i (ie_mask_i),
    .gie_i  (gie_i),
    .pick_o (irq_pick)
  );

  always_comb begin
    base   = {tvec_i[XLEN-1:2], 2'b00};
    take_d = exc_pick.hit | irq_pick.hit;
    if (exc_pick.hit) begin
      cause_d  = {{(XLEN-5){1'b0}}, exc_pick.code};
      target_d = base;
    end else begin
      cause_d  = {1'b1, {(XLEN-6){1'b0}}, irq_pick.code};
      target_d = (tvec_i[1:0] == MODE_VECTORED)
               ? base + {{(XLEN-7){1'b0}}, irq_pick.code, 2'b00}
               : base;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q   <= 1'b0;
      cause_q  <= '0;
      target_q <= '0;
    end else begin
      take_q <= take_d;
      if (take_d) begin
        cause_q  <= cause_d;
        target_q <= target_d;
      end
    end
  end

  assign pending_o = pend_q;
  assign take_o    = take_q;
  assign cause_o   = cause_q;
  assign target_o  = target_q;
endmodule

// File: rtl/trap_cause_arbiter_sva.sv
module trap_cause_arbiter_sva #(
  parameter int N_LOCAL    = 7,
  parameter int LOCAL_BASE = 16,
  parameter int EXT_BIT    = 11,
  parameter int TIMER_BIT  = 7
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exc_fetch_i,
  input logic        exc_illegal_i,
  input logic        exc_ebreak_i,
  input logic        exc_ecall_i,
  input logic        step_mode_i,
  input logic        retire_i,
  input logic        mem_valid_i,
  input logic        irq_ext_i,
  input logic        gie_i,
  input logic [31:0] pending_o,
  input logic        take_o,
  input logic [31:0] cause_o,
  input logic [31:0] target_o
);
  function automatic logic [31:0] wired_mask();
    logic [31:0] m;
    m = '0;
    m[EXT_BIT]   = 1'b1;
    m[TIMER_BIT] = 1'b1;
    for (int k = 0; k < N_LOCAL; k++) m[LOCAL_BASE + k] = 1'b1;
    return m;
  endfunction
  localparam logic [31:0] WIRED = wired_mask();

  assert_ext_pend_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> pending_o[EXT_BIT] == $past(irq_ext_i));

  assert_unwired_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o & ~WIRED) == 32'h0);

  assert_illegal_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && exc_illegal_i && !exc_fetch_i) |-> take_o && cause_o == 32'h2);

  assert_step_break_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && step_mode_i && retire_i && !exc_fetch_i && !exc_illegal_i)
      |-> take_o && cause_o == 32'h3);

  assert_exc_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && exc_ecall_i) |-> take_o && !cause_o[31]);

  assert_gate_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && !gie_i && !exc_fetch_i && !exc_illegal_i && !exc_ebreak_i &&
          !exc_ecall_i && !mem_valid_i && !(step_mode_i && retire_i)) |-> !take_o);

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && cause_o[31] |-> cause_o[30:5] == 26'h0);

  assert_exc_target_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !cause_o[31] |-> target_o[1:0] == 2'b00);

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(cause_o) && $stable(target_o));
endmodule

bind trap_cause_arbiter trap_cause_arbiter_sva #(
  .N_LOCAL(N_LOCAL), .LOCAL_BASE(LOCAL_BASE), .EXT_BIT(EXT_BIT), .TIMER_BIT(TIMER_BIT)
) sva_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exc_fetch_i   (exc_fetch_i),
  .exc_illegal_i (exc_illegal_i),
  .exc_ebreak_i  (exc_ebreak_i),
  .exc_ecall_i   (exc_ecall_i),
  .step_mode_i   (step_mode_i),
  .retire_i      (retire_i),
  .mem_valid_i   (mem_valid_i),
  .irq_ext_i     (irq_i[0]),
  .gie_i         (gie_i),
  .pending_o     (pending_o),
  .take_o        (take_o),
  .cause_o       (cause_o),
  .target_o      (target_o)
);

// File: tb/trap_cause_arbiter_tb_top.sv
`timescale 1ns/1ps
module trap_cause_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic fetch, illegal, ebreak, ecall, step_mode, retire;
  logic mem_valid, mem_we;
  logic [1:0] mem_size, addr_lo;
  logic [7:0] irq;
  logic timer, gie;
  logic [31:0] mask, tvec;
  logic [31:0] pending, cause, target;
  logic take;

  trap_cause_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_fetch_i(fetch), .exc_illegal_i(illegal), .exc_ebreak_i(ebreak), .exc_ecall_i(ecall),
    .step_mode_i(step_mode), .retire_i(retire),
    .mem_valid_i(mem_valid), .mem_we_i(mem_we), .mem_size_i(mem_size), .mem_addr_lo_i(addr_lo),
    .irq_i(irq), .timer_i(timer), .gie_i(gie), .ie_mask_i(mask), .tvec_i(tvec),
    .pending_o(pending), .take_o(take), .cause_o(cause), .target_o(target)
  );

  typedef struct {
    logic        take;
    logic [31:0] cause;
    logic [31:0] target;
    logic [31:0] pend;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_e;
  int checks = 0;
  int fails  = 0;
  logic [31:0] pend_m = '0;
  logic [31:0] last_cause = '0;
  logic [31:0] last_target = '0;
  bit done = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    fetch = 0; illegal = 0; ebreak = 0; ecall = 0; step_mode = 0; retire = 0;
    mem_valid = 0; mem_we = 0; mem_size = 0; addr_lo = 0; irq = 0; timer = 0;
  endtask

  // Driver: computes expected outputs after the next edge and queues them.
  task automatic step(input string tag);
    exp_t e;
    logic [31:0] pn, q, base;
    logic bad, ml, ms, eh, ih;
    logic [4:0] ec, ic;
    pn = '0;
    pn[11] = irq[0];
    pn[7]  = timer;
    for (int k = 0; k < 7; k++) pn[16 + k] = irq[k + 1];
    bad = (mem_size == 2'd2 && addr_lo != 2'b00) || (mem_size == 2'd1 && addr_lo[0]);
    ml = mem_valid && !mem_we && bad;
    ms = mem_valid && mem_we && bad;
    eh = 1'b1; ec = 5'd0;
    if (fetch) ec = 5'd0;
    else if (illegal) ec = 5'd2;
    else if (ebreak || (step_mode && retire)) ec = 5'd3;
    else if (ecall) ec = 5'd11;
    else if (ml) ec = 5'd4;
    else if (ms) ec = 5'd6;
    else eh = 1'b0;
    q = pend_m & mask; ih = 1'b0; ic = 5'd0;
    if (gie) begin
      if (q[11]) begin ih = 1; ic = 5'd11; end
      else if (q[7]) begin ih = 1; ic = 5'd7; end
      else for (int k = 6; k >= 0; k--) if (q[16 + k]) begin ih = 1; ic = 5'(16 + k); end
    end
    base = {tvec[31:2], 2'b00};
    if (eh) begin
      last_cause = {27'h0, ec}; last_target = base;
    end else if (ih) begin
      last_cause = 32'h8000_0000 | {27'h0, ic};
      last_target = (tvec[1:0] == 2'b01) ? base + {25'h0, ic, 2'b00} : base;
    end
    e.take = eh || ih; e.cause = last_cause; e.target = last_target;
    e.pend = pn; e.tag = tag;
    sb.push_back(e);
    pend_m = pn;
    @(negedge clk);
  endtask

  // Monitor: pops one expected item per edge once results start arriving.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      mon_e = sb.pop_front();
      chk(mon_e.tag, "take", {31'h0, take}, {31'h0, mon_e.take});
      chk(mon_e.tag, "cause", cause, mon_e.cause);
      chk(mon_e.tag, "target", target, mon_e.target);
      chk(mon_e.tag, "pending", pending, mon_e.pend);
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(); gie = 0; mask = '0; tvec = 32'h2000_0100;
    irq = 8'hFF; timer = 1;
    repeat (3) @(negedge clk);
    chk("R13", "reset take", {31'h0, take}, 32'h0);
    chk("R13", "reset cause", cause, 32'h0);
    chk("R13", "reset target", target, 32'h0);
    chk("R13", "reset pending", pending, 32'h0);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    step("R13");

    // R3: each exception alone
    fetch = 1; step("R3"); idle();
    illegal = 1; step("R3"); idle();
    ebreak = 1; step("R3"); idle();
    ecall = 1; step("R3"); idle();
    step("R12"); step("R12");

    // R4: priority chain among exceptions
    fetch = 1; illegal = 1; ebreak = 1; ecall = 1; mem_valid = 1; mem_size = 2; addr_lo = 1;
    step("R4"); fetch = 0; step("R4"); illegal = 0; step("R4"); ebreak = 0; step("R4");
    ecall = 0; step("R4"); mem_we = 1; step("R4"); idle();

    // R5: single step
    step_mode = 1; step("R5"); retire = 1; step("R5"); step_mode = 0; step("R5"); idle();

    // R6: misalignment table
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        for (int w = 0; w < 2; w++) begin
          mem_valid = 1; mem_size = 2'(s); addr_lo = 2'(a); mem_we = w[0];
          step("R6");
        end
    mem_valid = 0; mem_size = 2; addr_lo = 3; step("R6"); idle();

    // R10: direct target with mode bits other than 1
    tvec = 32'h3000_0042; ecall = 1; step("R10"); tvec = 32'h3000_0083; step("R10");
    tvec = 32'h2000_0100; idle();

    // R1/R2: pending map with all lines high, nothing enabled
    irq = 8'hFF; timer = 1; step("R2"); step("R1"); idle(); step("R1");

    // R9: gating
    mask = 32'hFFFF_FFFF; gie = 0; irq = 8'h01; step("R9"); step("R9");
    gie = 1; mask = 32'h0; step("R9"); mask = 32'h0000_0800; step("R9"); step("R9");
    irq = 0; step("R9"); step("R12"); step("R12");

    // R8: interrupt priority
    mask = 32'hFFFF_FFFF; irq = 8'hFF; timer = 1; step("R8"); step("R8");
    irq = 8'hFE; step("R8"); step("R8"); timer = 0; step("R8"); step("R8");
    irq = 8'hF0; step("R8"); step("R8"); irq = 8'h80; step("R8"); step("R8");
    mask = 32'h0040_0000; irq = 8'hC0; step("R8"); step("R8");
    mask = 32'hFFFF_FFFF; idle(); step("R8"); step("R8");

    // R7: exception beats pending interrupt
    irq = 8'h01; step("R7"); illegal = 1; step("R7"); illegal = 0; mem_valid = 1;
    mem_size = 1; addr_lo = 1; mem_we = 1; step("R7"); idle(); step("R7"); step("R7");

    // R11: vectored interrupts, exceptions stay at base
    tvec = 32'h2000_0101; irq = 8'h01; step("R11"); step("R11");
    irq = 8'h08; step("R11"); step("R11"); timer = 1; irq = 0; step("R11"); step("R11");
    idle(); ecall = 1; step("R11"); idle(); step("R12"); step("R12");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule